// File: doc/BRIEF.md
# Four-Beat Quad-Rate SRAM Port

This block models a quad-data-rate static memory port with independent read and write data paths. It runs from one clock at twice the command rate, so every clock edge stands for one half-period of the command clock. Edges alternate between command phases (K) and in-between phases (/K). The block drives an output `k_phase_o` that marks which kind of edge comes next, so the surrounding logic can line up its stimulus.

Commands are sampled only on K edges. Every command moves four words. The address bus carries a burst address, and the four words of burst `a` live at word addresses `4*a + 0 .. 4*a + 3`, visited in ascending order. Write data and the per-byte write enables are taken on both edge types, while read data is returned on both edge types after a fixed delay.

A read and a write can be accepted on the same K edge. Back-to-back commands keep both data buses busy with no gaps. The storage is an internal array split into byte lanes. Array reads are timed so that a read sees every write accepted up to one K edge after it.

Top module: `qdr4_sram`

## Requirements
- R1: After reset `k_phase_o` is 1 and it inverts on every clock edge. An edge is a K edge when `k_phase_o` was 1 just before it, and `rd_n`/`wr_n` are ignored on every other edge.
- R2: `rd_n` low at a K edge accepts a read of burst `addr`. The read returns words `4*addr+0` through `4*addr+3`, in that order.
- R3: After a strobe is accepted, the same strobe is ignored at the next K edge. It can be accepted again at the K edge after that. Reads and writes are blocked independently of each other.
- R4: `wr_n` low at a K edge accepts a write of burst `addr`. Write beat i (0..3) is sampled at the (i+1)-th clock edge after the command edge and goes to word `4*addr+i`.
- R5: Bit b of `bw_n` is sampled with each write beat. When that bit is low, byte b (`wdata` bits 8b+7..8b) of the beat is stored. When it is high, the stored byte keeps its old value.
- R6: For a read accepted at edge E, `rvalid` is 1 with beat i on `rdata` in the cycle after edge E+5+i. Beats 0 and 2 therefore land on /K edges and beats 1 and 3 on K edges. `rvalid` is 0 outside accepted beats.
- R7: In reset and whenever `rvalid` is 0, `rdata` is 0.
- R8: A read and a write accepted on the same K edge are both carried out. The read returns the words as written by that write.
- R9: A read returns the array contents including every write accepted at or before the K edge that follows the read's own command edge. Writes accepted later do not affect that read.
- R10: `addr`, `wdata` and `bw_n` have no effect on the array or the outputs when no strobe is accepted and no write burst is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; each edge is one half-period of K |
| rst | input | 1 | Synchronous active-high reset |
| k_phase_o | output | 1 | 1 when the next clock edge is a K edge |
| rd_n | input | 1 | Active-low read strobe, sampled on K edges |
| wr_n | input | 1 | Active-low write strobe, sampled on K edges |
| addr | input | BAW | Burst address of the command |
| wdata | input | DW | Write data beat |
| bw_n | input | DW/8 | Active-low byte write enables for the current beat |
| rdata | output | DW | Read data beat |
| rvalid | output | 1 | High while a read beat is on `rdata` |

## Verification
Results have fixed due times, counted in clock edges from the command edge. The phase output flips after every edge. Write beat i lands in the array at edge +1+i. The array read for read beat i happens at edge +4+i, and that beat becomes visible on the ports after edge +5+i. The bench builds the full input schedule, indexed by edge number, before it runs. A reference array, driven by that schedule, places each expected beat in the output slot of the edge on which it is due. The outputs are then sampled at the falling edge that follows each rising edge, so every comparison lands exactly one edge after the register that produces it updates.

// File: rtl/qdr4_pkg.sv
package qdr4_pkg;
  // words moved by one command
  localparam int BEATS = 4;
  // bits of the in-burst word index
  localparam int BEAT_W = 2;
  // clock edges from command edge to first array read of a read burst
  localparam int RD_ISSUE_DLY = 4;

  function automatic logic is_last_beat(input logic [BEAT_W-1:0] idx);
    return idx == BEAT_W'(BEATS - 1);
  endfunction
endpackage

// File: rtl/qdr4_phase_accept.sv
module qdr4_phase_accept (
  input  logic clk,
  input  logic rst,
  input  logic rd_n,
  input  logic wr_n,
  output logic k_phase,
  output logic rd_go,
  output logic wr_go
);
  logic rd_blk_q;
  logic wr_blk_q;

  // a strobe counts only on a K edge and not right after its own acceptance
  assign rd_go = k_phase & ~rd_n & ~rd_blk_q;
  assign wr_go = k_phase & ~wr_n & ~wr_blk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      k_phase  <= 1'b1;
      rd_blk_q <= 1'b0;
      wr_blk_q <= 1'b0;
    end else begin
      k_phase <= ~k_phase;
      if (k_phase) begin
        rd_blk_q <= rd_go;
        wr_blk_q <= wr_go;
      end
    end
  end
endmodule

// File: rtl/qdr4_wr_seq.sv
module qdr4_wr_seq
  import qdr4_pkg::*;
#(
  parameter int BAW = 6,
  parameter int DW  = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_go,
  input  logic [BAW-1:0]        base,
  input  logic [DW-1:0]         wdata,
  input  logic [DW/8-1:0]       bw_n,
  output logic [DW/8-1:0]       mem_we,
  output logic [BAW+BEAT_W-1:0] mem_waddr,
  output logic [DW-1:0]         mem_wdata
);
  logic              act_q;
  logic [BAW-1:0]    base_q;
  logic [BEAT_W-1:0] cnt_q;

  // one beat per edge while a burst is open; lanes gated by the enables
  assign mem_we    = act_q ? ~bw_n : '0;
  assign mem_waddr = {base_q, cnt_q};
  assign mem_wdata = wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
    end else begin
      if (act_q) begin
        cnt_q <= cnt_q + BEAT_W'(1);
        if (is_last_beat(cnt_q)) act_q <= 1'b0;
      end
      if (wr_go) begin
        act_q  <= 1'b1;
        cnt_q  <= '0;
        base_q <= base;
      end
    end
  end
endmodule

// File: rtl/qdr4_rd_seq.sv
module qdr4_rd_seq
  import qdr4_pkg::*;
#(
  parameter int BAW = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_go,
  input  logic [BAW-1:0]        base,
  output logic                  mem_re,
  output logic [BAW+BEAT_W-1:0] mem_raddr
);
  localparam int LAST = RD_ISSUE_DLY - 1;

  logic           dly_v [RD_ISSUE_DLY];
  logic [BAW-1:0] dly_b [RD_ISSUE_DLY];

  always_ff @(posedge clk) begin
    if (rst) begin
      dly_v[0] <= 1'b0;
      dly_b[0] <= '0;
    end else begin
      dly_v[0] <= rd_go;
      dly_b[0] <= base;
    end
  end

  for (genvar g = 1; g < RD_ISSUE_DLY; g++) begin : g_dly
    always_ff @(posedge clk) begin
      if (rst) begin
        dly_v[g] <= 1'b0;
        dly_b[g] <= '0;
      end else begin
        dly_v[g] <= dly_v[g-1];
        dly_b[g] <= dly_b[g-1];
      end
    end
  end

  logic              act_q;
  logic [BAW-1:0]    base_q;
  logic [BEAT_W-1:0] cnt_q;

  // beat 0 is read straight from the delay line; beats 1..3 from the counter
  assign mem_re    = dly_v[LAST] | act_q;
  assign mem_raddr = dly_v[LAST] ? {dly_b[LAST], {BEAT_W{1'b0}}} : {base_q, cnt_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (dly_v[LAST]) begin
      act_q  <= 1'b1;
      base_q <= dly_b[LAST];
      cnt_q  <= BEAT_W'(1);
    end else if (act_q) begin
      cnt_q <= cnt_q + BEAT_W'(1);
      if (is_last_beat(cnt_q)) act_q <= 1'b0;
    end
  end
endmodule

// File: rtl/qdr4_store.sv
module qdr4_store #(
  parameter int WAW = 8,
  parameter int DW  = 32
) (
  input  logic            clk,
  input  logic [DW/8-1:0] we,
  input  logic [WAW-1:0]  waddr,
  input  logic [DW-1:0]   wdata,
  input  logic            re,
  input  logic [WAW-1:0]  raddr,
  output logic [DW-1:0]   rdata_q
);
  localparam int NB    = DW / 8;
  localparam int DEPTH = 1 << WAW;

  // one simple dual-port array per byte lane, read-before-write
  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we[b]) lane_mem[waddr] <= wdata[b*8 +: 8];
      if (re)    rdata_q[b*8 +: 8] <= lane_mem[raddr];
    end
  end
endmodule

// File: rtl/qdr4_sram.sv
module qdr4_sram
  import qdr4_pkg::*;
#(
  parameter int BAW = 6,
  parameter int DW  = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic            k_phase_o,
  input  logic            rd_n,
  input  logic            wr_n,
  input  logic [BAW-1:0]  addr,
  input  logic [DW-1:0]   wdata,
  input  logic [DW/8-1:0] bw_n,
  output logic [DW-1:0]   rdata,
  output logic            rvalid
);
  localparam int NB  = DW / 8;
  localparam int WAW = BAW + BEAT_W;

  logic           rd_go;
  logic           wr_go;
  logic [NB-1:0]  mem_we;
  logic [WAW-1:0] mem_waddr;
  logic [DW-1:0]  mem_wdata;
  logic           mem_re;
  logic [WAW-1:0] mem_raddr;
  logic [DW-1:0]  arr_q;
  logic           arr_v_q;

  qdr4_phase_accept u_acc (
    .clk     (clk),
    .rst     (rst),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .k_phase (k_phase_o),
    .rd_go   (rd_go),
    .wr_go   (wr_go)
  );

  qdr4_wr_seq #(.BAW(BAW), .DW(DW)) u_wr (
    .clk       (clk),
    .rst       (rst),
    .wr_go     (wr_go),
    .base      (addr),
    .wdata     (wdata),
    .bw_n      (bw_n),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata)
  );

  qdr4_rd_seq #(.BAW(BAW)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_go     (rd_go),
    .base      (addr),
    .mem_re    (mem_re),
    .mem_raddr (mem_raddr)
  );

  qdr4_store #(.WAW(WAW), .DW(DW)) u_mem (
    .clk     (clk),
    .we      (mem_we),
    .waddr   (mem_waddr),
    .wdata   (mem_wdata),
    .re      (mem_re),
    .raddr   (mem_raddr),
    .rdata_q (arr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      arr_v_q <= 1'b0;
      rvalid  <= 1'b0;
      rdata   <= '0;
    end else begin
      arr_v_q <= mem_re;
      rvalid  <= arr_v_q;
      rdata   <= arr_v_q ? arr_q : '0;
    end
  end
endmodule

// File: rtl/qdr4_sram_chk.sv
module qdr4_sram_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          k_phase,
  input logic          rd_go,
  input logic          wr_go,
  input logic          rvalid,
  input logic [DW-1:0] rdata
);
  logic [1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) run_q <= 2'd0;
    else     run_q <= rvalid ? run_q + 2'd1 : 2'd0;
  end

  // R1
  phase_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (k_phase != $past(k_phase)));

  // R1
  go_on_k_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_go || wr_go) |-> k_phase);

  // R3
  rd_gap_chk: assert property (@(posedge clk) disable iff (rst)
    rd_go |-> ##2 !rd_go);

  // R3
  wr_gap_chk: assert property (@(posedge clk) disable iff (rst)
    wr_go |-> ##2 !wr_go);

  // R6
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    rd_go |-> ##6 rvalid);

  // R6
  burst_run_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rvalid) |-> (run_q == 2'd0));

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rvalid |-> (rdata == '0));
endmodule

bind qdr4_sram qdr4_sram_chk #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .k_phase (k_phase_o),
  .rd_go   (rd_go),
  .wr_go   (wr_go),
  .rvalid  (rvalid),
  .rdata   (rdata)
);

// File: tb/qdr4_sram_tb.sv
`timescale 1ns/1ps
module qdr4_sram_tb_top;
  localparam int BAW   = 2;
  localparam int DW    = 16;
  localparam int NB    = DW / 8;
  localparam int WORDS = 1 << (BAW + 2);
  localparam int N     = 2300;
  localparam int NX    = N + 16;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           rd_n = 1'b1;
  logic           wr_n = 1'b1;
  logic [BAW-1:0] addr = '0;
  logic [DW-1:0]  wdata = '0;
  logic [NB-1:0]  bw_n = '1;
  logic [DW-1:0]  rdata;
  logic           rvalid;
  logic           k_phase_o;

  always #4 clk = ~clk;

  qdr4_sram #(.BAW(BAW), .DW(DW)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .k_phase_o (k_phase_o),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .addr      (addr),
    .wdata     (wdata),
    .bw_n      (bw_n),
    .rdata     (rdata),
    .rvalid    (rvalid)
  );

  bit             c_rd [NX];
  bit             c_wr [NX];
  logic [BAW-1:0] c_a  [NX];
  logic [DW-1:0]  c_wd [NX];
  logic [NB-1:0]  c_bw [NX];
  bit             wb_v [NX];
  logic [BAW+1:0] wb_a [NX];
  bit             rb_v [NX];
  logic [BAW+1:0] rb_a [NX];
  bit             ev   [NX];
  logic [DW-1:0]  ed   [NX];
  logic [DW-1:0]  mdl  [WORDS];

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp,
                     input string what, input int e);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s edge %0d: actual %h expected %h", req, what, e, act, exp);
    end
  endtask

  function automatic string data_tag(input int e, input bit vld);
    if (!vld)        return "R7";
    if (e < 40)      return "R2/R3/R4/R5";
    if (e < 2000)    return "R5/R8/R9";
    if (e < 2240)    return "R10";
    return "R8/R9";
  endfunction

  task automatic build_schedule();
    for (int e = 0; e < NX; e++) begin
      c_rd[e] = 1'b0; c_wr[e] = 1'b0;
      c_a[e]  = BAW'($urandom);
      c_wd[e] = DW'($urandom);
      c_bw[e] = NB'($urandom);
      wb_v[e] = 1'b0; rb_v[e] = 1'b0; wb_a[e] = '0; rb_a[e] = '0;
      ev[e] = 1'b0; ed[e] = '0;
      if (e < 16) begin                       // R3: strobe held low, every other K edge taken
        c_wr[e] = 1'b1;
        c_a[e]  = (e % 4 == 0) ? BAW'(e / 4) : ~BAW'(e / 4);
      end
      if (e <= 20) c_bw[e] = '0;              // full-word fill
      if (e >= 20 && e < 36) begin            // R2: read every burst back
        c_rd[e] = 1'b1;
        c_a[e]  = (e % 4 == 0) ? BAW'((e - 20) / 4) : ~BAW'((e - 20) / 4);
      end
      if (e >= 40 && e < 2000) begin          // mixed traffic, odd-edge strobes too (R1)
        c_rd[e] = ($urandom % 2) == 1;
        c_wr[e] = ($urandom % 2) == 1;
      end
      if (e >= 2200 && e < 2216) begin        // R10: reread after idle address activity
        c_rd[e] = 1'b1;
        c_a[e]  = BAW'((e - 2200) / 4);
      end
      if (e == 2240 || e == 2244) begin       // R8: read and write on one edge
        c_rd[e] = 1'b1; c_wr[e] = 1'b1;
        c_a[e]  = (e == 2240) ? BAW'(2) : BAW'(3);
      end
    end
  endtask

  task automatic run_model();
    bit rblk = 1'b0;
    bit wblk = 1'b0;
    bit ra, wa;
    for (int w = 0; w < WORDS; w++) mdl[w] = '0;
    for (int e = 0; e < N; e++) begin
      if (e % 2 == 0) begin
        ra = c_rd[e] && !rblk;
        wa = c_wr[e] && !wblk;
        rblk = ra;
        wblk = wa;
        for (int i = 0; i < 4; i++) begin
          if (ra) begin rb_v[e+4+i] = 1'b1; rb_a[e+4+i] = {c_a[e], 2'(i)}; end
          if (wa) begin wb_v[e+1+i] = 1'b1; wb_a[e+1+i] = {c_a[e], 2'(i)}; end
        end
      end
      if (rb_v[e]) begin
        ev[e+1] = 1'b1;
        ed[e+1] = mdl[rb_a[e]];
      end
      if (wb_v[e])
        for (int b = 0; b < NB; b++)
          if (!c_bw[e][b]) mdl[wb_a[e]][b*8 +: 8] = c_wd[e][b*8 +: 8];
    end
  endtask

  initial begin
    build_schedule();
    run_model();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1", DW'(k_phase_o), DW'(1), "phase after reset", -1);
    chk("R7", DW'(rvalid), '0, "rvalid after reset", -1);
    chk("R7", rdata, '0, "rdata after reset", -1);
    for (int e = 0; e < N; e++) begin
      rd_n  = ~c_rd[e];
      wr_n  = ~c_wr[e];
      addr  = c_a[e];
      wdata = c_wd[e];
      bw_n  = c_bw[e];
      @(posedge clk);
      @(negedge clk);
      chk("R1", DW'(k_phase_o), DW'(e % 2), "phase", e);
      chk("R6", DW'(rvalid), DW'(ev[e]), "rvalid", e);
      chk(data_tag(e, ev[e]), rdata, ev[e] ? ed[e] : '0, "rdata", e);
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R6 watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule